// File: doc/BRIEF.md
# Bidirectional GPIO Bank with Peripheral Takeover

This block is a parameterized bank of general-purpose pins with a small register interface. Software sets an output value and a direction for each pin, and reads back the levels seen at the pads. The pad-facing side carries a drive value, a drive enable and a raw input for every pin. These connect to the chip's I/O cells.

Any pin can be claimed by an on-chip peripheral. While the claim is active, the peripheral decides whether the pin drives and what value it drives. It can also cut the pin's digital input path, so that toggling on its own output does not reach the input side. Pins that have an analog function start in analog mode after reset. In that mode the digital input reads as zero until software clears the pin's bit in the analog-select register. Raw pad inputs pass through a multi-flop synchronizer before software or peripherals see them.

Top module: `gpio_bank`

## Requirements
- R1: After reset the data latch is all zeros, the direction register reads all ones so that no pad drives (pad_oe = 0), and the analog-select register reads ANALOG_CAPABLE (default 8'h2F).
- R2: Register addresses: 0 selects the data register, 1 the direction register, 2 the analog-select register. A direction bit of 0 makes that pin drive (pad_oe bit = 1) and a 1 makes it an input. The bits are independent, and the direction register reads back what was written.
- R3: A write to address 0 updates the data latch even while the pin is an input. For a pin that no peripheral claims, pad_out always shows the latch, so the value drives as soon as the pin becomes an output.
- R4: While alt_en is 1 for a pin, that pin's pad_oe equals alt_oe and its pad_out equals alt_out, whatever the latches hold.
- R5: A pin with both alt_en and alt_in_block at 1 reads as 0 at data address 0 and on alt_in. A pin with alt_en at 1 and alt_in_block at 0 still passes its input.
- R6: A pin whose analog-select bit is 1 reads as 0 at address 0 and on alt_in. Only bits set in ANALOG_CAPABLE can be set; the other bits always read 0.
- R7: A change on pad_in shows at address 0 and on alt_in after exactly SYNC_STAGES (default 2) rising edges, and not earlier.
- R8: Address 3 reads as 0, and writes to it change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 analog-select |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data for reg_addr |
| pad_in | input | WIDTH | Raw levels from the pads |
| pad_out | output | WIDTH | Value driven to the pads |
| pad_oe | output | WIDTH | Pad drive enable, 1 = drive |
| alt_en | input | WIDTH | Peripheral claims the pin |
| alt_oe | input | WIDTH | Peripheral drive enable for claimed pins |
| alt_out | input | WIDTH | Peripheral output value for claimed pins |
| alt_in_block | input | WIDTH | Peripheral blocks the digital input of claimed pins |
| alt_in | output | WIDTH | Synchronized, gated pin inputs for peripherals |

## Verification
On every cycle the assertions check that claimed pins follow the peripheral's drive enable. They also check that register writes show up on the next cycle on unclaimed pins' pad_oe and pad_out, that blocked and analog pins never present a 1 on alt_in, and that no 1 reaches alt_in ahead of the synchronizer delay. The reset values, the exact arrival edge of an input change, the read-back of each register, the masking of non-analog bits and the inert fourth address are shown only by the bench's sweeps.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      GP_DATA = 2'd0,
      GP_DIR  = 2'd1,
      GP_ANA  = 2'd2,
      GP_NONE = 2'd3
   } gp_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int               WIDTH          = 8,
   parameter logic [WIDTH-1:0] ANALOG_CAPABLE = WIDTH'(47)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] ana_q
);
   gp_reg_e sel;
   assign sel = gp_reg_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '1;
         ana_q  <= ANALOG_CAPABLE;
      end else if (wr) begin
         case (sel)
            GP_DATA: data_q <= wdata;
            GP_DIR:  dir_q  <= wdata;
            GP_ANA:  ana_q  <= wdata & ANALOG_CAPABLE;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] ana_q,
   input  logic [WIDTH-1:0] sync_in,
   input  logic [WIDTH-1:0] alt_en,
   input  logic [WIDTH-1:0] alt_oe,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] alt_in_block,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] dig_in
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic in_pass;
      assign pad_oe[i]  = alt_en[i] ? alt_oe[i]  : ~dir_q[i];
      assign pad_out[i] = alt_en[i] ? alt_out[i] : data_q[i];
      assign in_pass    = ~ana_q[i] & ~(alt_en[i] & alt_in_block[i]);
      assign dig_in[i]  = sync_in[i] & in_pass;
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int               WIDTH          = 8,
   parameter int               SYNC_STAGES    = 2,
   parameter logic [WIDTH-1:0] ANALOG_CAPABLE = WIDTH'(47)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [WIDTH-1:0] reg_wdata,
   output logic [WIDTH-1:0] reg_rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   input  logic [WIDTH-1:0] alt_en,
   input  logic [WIDTH-1:0] alt_oe,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] alt_in_block,
   output logic [WIDTH-1:0] alt_in
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_bank: WIDTH must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_bank: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] data_q, dir_q, ana_q, sync_in, dig_in;

   gpio_regs #(.WIDTH(WIDTH), .ANALOG_CAPABLE(ANALOG_CAPABLE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .data_q(data_q), .dir_q(dir_q), .ana_q(ana_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_in)
   );

   gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
      .data_q(data_q), .dir_q(dir_q), .ana_q(ana_q), .sync_in(sync_in),
      .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .alt_in_block(alt_in_block),
      .pad_out(pad_out), .pad_oe(pad_oe), .dig_in(dig_in)
   );

   assign alt_in = dig_in;

   always_comb begin
      case (gp_reg_e'(reg_addr))
         GP_DATA: reg_rdata = dig_in;
         GP_DIR:  reg_rdata = dir_q;
         GP_ANA:  reg_rdata = ana_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [WIDTH-1:0] reg_wdata,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] alt_en,
   input logic [WIDTH-1:0] alt_oe,
   input logic [WIDTH-1:0] alt_in_block,
   input logic [WIDTH-1:0] alt_in,
   input logic [WIDTH-1:0] ana_q
);
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1) |=> (((pad_oe ^ ~$past(reg_wdata)) & ~alt_en) == '0)); // R2
   AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0) |=> (((pad_out ^ $past(reg_wdata)) & ~alt_en) == '0)); // R3
   AST_ALT_OE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe ^ alt_oe) & alt_en) == '0); // R4
   AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_in & alt_en & alt_in_block) == '0); // R5
   AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_in & ana_q) == '0); // R6
   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_in & ~$past(pad_in, 2)) == '0); // R7
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .alt_en(alt_en), .alt_oe(alt_oe),
   .alt_in_block(alt_in_block), .alt_in(alt_in), .ana_q(ana_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] CAP = 8'h2F;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       reg_wr = 0;
   logic [1:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0, reg_rdata;
   logic [7:0] pad_in = 8'hFF, pad_out, pad_oe;
   logic [7:0] alt_en = 0, alt_oe = 0, alt_out = 0, alt_in_block = 0, alt_in;
   int errors = 0, checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .alt_in_block(alt_in_block),
      .alt_in(alt_in)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic [7:0] prev;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      repeat (3) @(posedge clk); #1;
      // R1 reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      rd(2'd1, r); check("R1 dir", r, 8'hFF);
      rd(2'd2, r); check("R1 analog", r, CAP);
      rd(2'd0, r); check("R6 reset analog gating", r, 8'hFF & ~CAP);

      // R6 analog mask sweep, pad_in all ones
      for (int m = 0; m < 256; m++) begin
         wr(2'd2, 8'(m));
         rd(2'd2, r); check("R6 analog readback", r, 8'(m) & CAP);
         rd(2'd0, r); check("R6 data gated", r, ~(8'(m) & CAP));
         check("R6 alt_in gated", alt_in, ~(8'(m) & CAP));
      end
      wr(2'd2, 8'h00);

      // R2 / R3 direction and data sweep
      for (int v = 0; v < 256; v++) begin
         wr(2'd1, 8'(v));
         check("R2 pad_oe", pad_oe, ~8'(v));
         rd(2'd1, r); check("R2 dir readback", r, 8'(v));
         wr(2'd0, 8'(v) ^ 8'h5A);
         check("R3 pad_out", pad_out, 8'(v) ^ 8'h5A);
      end

      // R3 latch written while input, then turned to output
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h3C);
      check("R3 input hides drive", pad_oe, 8'h00);
      wr(2'd1, 8'h00);
      check("R3 latch driven", pad_out, 8'h3C);
      check("R3 now driving", pad_oe, 8'hFF);

      // R7 synchronizer latency sweep
      prev = 8'hFF;
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); pad_in = 8'(v);
         @(posedge clk); #1;
         rd(2'd0, r); check("R7 not after one edge", r, prev);
         @(posedge clk); #1;
         rd(2'd0, r); check("R7 after two edges", r, 8'(v));
         check("R7 alt_in", alt_in, 8'(v));
         prev = 8'(v);
      end

      // R4 / R5 peripheral override sweep
      wr(2'd1, 8'h0F);
      wr(2'd0, 8'hC3);
      @(negedge clk);
      pad_in = 8'hFF; alt_oe = 8'hA5; alt_out = 8'h3C; alt_in_block = 8'hF0;
      repeat (3) @(posedge clk);
      for (int m = 0; m < 256; m++) begin
         @(negedge clk); alt_en = 8'(m); #1;
         check("R4 pad_oe", pad_oe, (8'(m) & 8'hA5) | (~8'(m) & 8'hF0));
         check("R4 pad_out", pad_out, (8'(m) & 8'h3C) | (~8'(m) & 8'hC3));
         check("R5 alt_in", alt_in, ~(8'(m) & 8'hF0));
         rd(2'd0, r); check("R5 data read", r, ~(8'(m) & 8'hF0));
      end
      @(negedge clk); alt_en = 0;

      // R8 fourth address
      rd(2'd3, r); check("R8 read zero", r, 8'h00);
      wr(2'd3, 8'hA5);
      rd(2'd1, r); check("R8 dir unchanged", r, 8'h0F);
      rd(2'd2, r); check("R8 analog unchanged", r, 8'h00);
      check("R8 pad_out unchanged", pad_out, 8'hC3);
      check("R8 pad_oe unchanged", pad_oe, 8'hF0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule